// File: doc/BRIEF.md
# Legacy 16-bit Expansion Bus Slave Front End

This block sits behind the pins of a card on a legacy 16-bit expansion bus and turns the bus's asynchronous strobes into accesses to a small internal register store. Every bus input is brought into a fast internal clock through a two-stage synchronizer. All decisions are made on the synchronized copies, so the logic does not depend on the bus clock's frequency or duty cycle.

The upper address bits arrive on latchable lines that are only guaranteed while the address strobe is high. The block keeps its own copy, which follows those lines while the strobe is high and freezes when it falls. The strobe stays high during DMA and bus-master cycles, so in those cycles the copy simply follows the live lines. The resulting address is matched against a memory window and an I/O window. The I/O window is masked whenever the address-enable line reports a DMA cycle.

For each hit, the block raises the matching 16-bit capability flag. It then serves reads by driving the selected data lanes, and it commits writes when the write strobe is released. The byte lanes used are chosen from the high-byte enable and address bit 0.

Top module: `isa_slave_front`

## Requirements
- R1: While reset is held and on the first clock after it, both output-enable bits are 0, data_o is 0, and m16_n_o and io16_n_o are 1.
- R2: After the synchronized address strobe falls, memory decoding uses the upper address captured at the last clock it was high, whatever the latchable lines do afterwards.
- R3: While the synchronized address strobe is high, the upper address used for decoding is the live latchable value (DMA and bus-master cycles).
- R4: m16_n_o is 0 exactly when {upper address, sa_i[16:0]} bits 23..MEM_AW equal those of MEM_BASE. This is seen three clocks after the inputs settle: two synchronizer stages plus one output register.
- R5: io16_n_o is 0 exactly when aen_i is 0 and sa_i[15:IO_AW] equals IO_BASE[15:IO_AW]. When aen_i is 1, I/O writes leave the store unchanged and I/O reads drive nothing.
- R6: A write commits the lanes chosen by {sbhe_n_i, sa_i[0]}. 00 writes the whole word from data_i. 10 writes the low byte from data_i[7:0]. 01 writes the high byte from data_i[15:8]. 11 writes the high byte from data_i[7:0]. The word index is the address above bit 0.
- R7: A read with a hit drives lanes by the same code. 00 gives the word with data_oe_o=11. 10 gives the low byte on [7:0] with 01. 01 gives the high byte on [15:8] with 10. 11 gives the high byte on [7:0] with 01. Undriven lanes read as 0.
- R8: A write takes effect on the synchronized rising (release) edge of mwtc_n_i or iowc_n_i, using the address and data present at that edge. A read ending before that edge returns the old contents.
- R9: data_oe_o returns to 00 on the clock after the synchronized read strobe deasserts or stops hitting.
- R10: Accesses outside both windows change no stored data and drive no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bale_i | input | 1 | Address latch strobe, high while upper address is valid |
| aen_i | input | 1 | High during DMA; masks I/O decoding |
| la_i | input | LA_W | Latchable upper address lines (bits 23..17) |
| sa_i | input | SA_W | System address lines |
| sbhe_n_i | input | 1 | High-byte enable, active low |
| mrdc_n_i | input | 1 | Memory read strobe, active low |
| mwtc_n_i | input | 1 | Memory write strobe, active low |
| iorc_n_i | input | 1 | I/O read strobe, active low |
| iowc_n_i | input | 1 | I/O write strobe, active low |
| data_i | input | 16 | Data lanes seen from the bus |
| data_o | output | 16 | Read data for the bus |
| data_oe_o | output | 2 | Per-lane output enable, bit 0 low lane, bit 1 high lane |
| m16_n_o | output | 1 | Memory window hit, 16-bit capable, active low |
| io16_n_o | output | 1 | I/O window hit, 16-bit capable, active low |

## Verification
The assertions assume that every bus input holds its value for at least two internal clocks around each strobe edge. They also assume that address, lane code and write data stay valid until the released write strobe has passed both synchronizer stages. The stimulus meets this by holding each phase of a bus cycle for several clocks and keeping address and data steady for four clocks after each strobe is released. It never asserts a memory read and an I/O read at the same time. Changes to the latchable lines are applied only after the address strobe has fallen, or during DMA while it stays high.

// File: rtl/isa_slave_pkg.sv
// Shared types for the expansion bus slave front end.
// Assumes: the lane code is formed as {high-byte-enable_n, address bit 0}.
package isa_slave_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        LANE_WORD   = 2'b00,
        LANE_ODD_HI = 2'b01,
        LANE_EVEN   = 2'b10,
        LANE_ODD_LO = 2'b11
    } lane_e;

endpackage

// File: rtl/isa_sync.sv
// Two-stage synchronizer for a vector of asynchronous bus inputs.
// Assumes: each input bit is stable for at least two clocks around any edge
// that matters; the vector is not treated as coherent.
module isa_sync #(
    parameter int               WIDTH   = 8,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1;

    // Two flops in series per bit, reset to the idle bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            sync_o <= RST_VAL;
        end else begin
            stage1 <= async_i;
            sync_o <= stage1;
        end
    end

endmodule

// File: rtl/isa_addr_latch.sv
// Upper-address holder: follows the synchronized latchable lines while the
// address strobe is high and keeps the last value once it falls.
// Assumes: the strobe and address come from the same synchronizer.
module isa_addr_latch #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         open_i,
    input  logic [W-1:0] addr_i,
    output logic [W-1:0] addr_o
);

    logic [W-1:0] held;

    // Track the live address while open; freeze on the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      held <= '0;
        else if (open_i) held <= addr_i;
    end

    assign addr_o = open_i ? addr_i : held;

    // R2: the frozen copy is the value present at the last open clock.
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(open_i) |-> held == $past(addr_i));

    // R2: with the strobe low on two clocks, the used address does not move.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_i && $past(!open_i)) |-> $stable(addr_o));

endmodule

// File: rtl/isa_lane_steer.sv
// Byte-lane steering between the 16-bit bus and a 16-bit stored word.
// Assumes: lane code {sbhe_n, a0}; an unselected lane is driven as zero.
module isa_lane_steer
    import isa_slave_pkg::*;
(
    input  lane_e                 lane_i,
    input  logic [2*LANE_W-1:0]   bus_wdata_i,
    input  logic [2*LANE_W-1:0]   word_rdata_i,
    output logic [1:0]            word_be_o,
    output logic [2*LANE_W-1:0]   word_wdata_o,
    output logic [2*LANE_W-1:0]   bus_rdata_o,
    output logic [1:0]            bus_oe_o
);

    logic [LANE_W-1:0] bus_lo, bus_hi, word_lo, word_hi;

    assign {bus_hi, bus_lo}   = bus_wdata_i;
    assign {word_hi, word_lo} = word_rdata_i;

    // Map the lane code onto write enables, write placement and read placement.
    always_comb begin
        unique case (lane_i)
            LANE_WORD: begin
                word_be_o    = 2'b11;
                word_wdata_o = bus_wdata_i;
                bus_rdata_o  = word_rdata_i;
                bus_oe_o     = 2'b11;
            end
            LANE_EVEN: begin
                word_be_o    = 2'b01;
                word_wdata_o = {{LANE_W{1'b0}}, bus_lo};
                bus_rdata_o  = {{LANE_W{1'b0}}, word_lo};
                bus_oe_o     = 2'b01;
            end
            LANE_ODD_HI: begin
                word_be_o    = 2'b10;
                word_wdata_o = {bus_hi, {LANE_W{1'b0}}};
                bus_rdata_o  = {word_hi, {LANE_W{1'b0}}};
                bus_oe_o     = 2'b10;
            end
            default: begin
                word_be_o    = 2'b10;
                word_wdata_o = {bus_lo, {LANE_W{1'b0}}};
                bus_rdata_o  = {{LANE_W{1'b0}}, word_hi};
                bus_oe_o     = 2'b01;
            end
        endcase
    end

endmodule

// File: rtl/isa_regfile.sv
// Small word store with per-byte write enables and an asynchronous read.
// Assumes: one shared address for read and write; a same-cycle read sees
// the old contents.
module isa_regfile
    import isa_slave_pkg::*;
#(
    parameter int WORD_AW = 4,
    localparam int DEPTH  = 1 << WORD_AW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [1:0]            be_i,
    input  logic [WORD_AW-1:0]    addr_i,
    input  logic [2*LANE_W-1:0]   wdata_i,
    output logic [2*LANE_W-1:0]   rdata_o
);

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        // Clear on reset; otherwise commit this byte lane when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
            end else if (we_i && be_i[g]) begin
                bank[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = bank[addr_i];
    end

    // R8/R10: without a write, reading the same word again returns the same data.
    p_no_spurious_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> (!$stable(addr_i) || $stable(rdata_o)));

endmodule

// File: rtl/isa_slave_front.sv
// Slave front end for a legacy 16-bit expansion bus.
// Synchronizes the bus, holds the upper address, decodes a memory and an
// I/O window, steers byte lanes and commits writes on strobe release.
// Assumes: clk is several times faster than the bus clock; inputs hold for
// at least two clk periods around every strobe edge.
module isa_slave_front
    import isa_slave_pkg::*;
#(
    parameter int                        LA_W      = 7,
    parameter int                        LA_LSB    = 17,
    parameter int                        SA_W      = 20,
    parameter int                        IO_ADDR_W = 16,
    parameter logic [LA_W+LA_LSB-1:0]    MEM_BASE  = 24'h0D8000,
    parameter int                        MEM_AW    = 5,
    parameter logic [IO_ADDR_W-1:0]      IO_BASE   = 16'h0300,
    parameter int                        IO_AW     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bale_i,
    input  logic             aen_i,
    input  logic [LA_W-1:0]  la_i,
    input  logic [SA_W-1:0]  sa_i,
    input  logic             sbhe_n_i,
    input  logic             mrdc_n_i,
    input  logic             mwtc_n_i,
    input  logic             iorc_n_i,
    input  logic             iowc_n_i,
    input  logic [15:0]      data_i,
    output logic [15:0]      data_o,
    output logic [1:0]       data_oe_o,
    output logic             m16_n_o,
    output logic             io16_n_o
);

    localparam int FULL_W   = LA_W + LA_LSB;
    localparam int DATA_W   = 2 * LANE_W;
    localparam int CTRL_W   = 7;
    localparam int SYNC_W   = CTRL_W + LA_W + SA_W + DATA_W;
    localparam int MEM_WAW  = MEM_AW - 1;
    localparam int IO_WAW   = IO_AW - 1;
    localparam logic [SYNC_W-1:0] SYNC_IDLE =
        {3'b001, 4'b1111, {LA_W{1'b0}}, {SA_W{1'b0}}, {DATA_W{1'b0}}};

    logic              bale_s, aen_s, sbhe_n_s;
    logic              mrdc_n_s, mwtc_n_s, iorc_n_s, iowc_n_s;
    logic [LA_W-1:0]   la_s, la_eff;
    logic [SA_W-1:0]   sa_s;
    logic [DATA_W-1:0] d_s;
    logic [SYNC_W-1:0] sync_vec;

    isa_sync #(.WIDTH(SYNC_W), .RST_VAL(SYNC_IDLE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bale_i, aen_i, sbhe_n_i, mrdc_n_i, mwtc_n_i, iorc_n_i,
                   iowc_n_i, la_i, sa_i, data_i}),
        .sync_o  (sync_vec)
    );

    assign {bale_s, aen_s, sbhe_n_s, mrdc_n_s, mwtc_n_s, iorc_n_s, iowc_n_s,
            la_s, sa_s, d_s} = sync_vec;

    isa_addr_latch #(.W(LA_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_i (bale_s),
        .addr_i (la_s),
        .addr_o (la_eff)
    );

    // Window decode on the combined address.
    logic [FULL_W-1:0] full_addr;
    logic              mem_hit, io_hit;

    assign full_addr = {la_eff, sa_s[LA_LSB-1:0]};
    assign mem_hit   = full_addr[FULL_W-1:MEM_AW] == MEM_BASE[FULL_W-1:MEM_AW];
    assign io_hit    = !aen_s &&
                       (sa_s[IO_ADDR_W-1:IO_AW] == IO_BASE[IO_ADDR_W-1:IO_AW]);

    // Previous write strobe levels, for release-edge detection.
    logic mw_prev, iow_prev;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mw_prev  <= 1'b1;
            iow_prev <= 1'b1;
        end else begin
            mw_prev  <= mwtc_n_s;
            iow_prev <= iowc_n_s;
        end
    end

    logic mem_we, io_we, mem_rd, io_rd;
    assign mem_we = mem_hit && mwtc_n_s && !mw_prev;
    assign io_we  = io_hit  && iowc_n_s && !iow_prev;
    assign mem_rd = mem_hit && !mrdc_n_s;
    assign io_rd  = io_hit  && !iorc_n_s;

    // Lane steering shared by both windows.
    lane_e             lane;
    logic [1:0]        word_be, lane_oe;
    logic [DATA_W-1:0] word_wdata, bus_rdata, rd_word, mem_rdata, io_rdata;

    assign lane    = lane_e'({sbhe_n_s, sa_s[0]});
    assign rd_word = mem_rd ? mem_rdata : io_rdata;

    isa_lane_steer u_steer (
        .lane_i       (lane),
        .bus_wdata_i  (d_s),
        .word_rdata_i (rd_word),
        .word_be_o    (word_be),
        .word_wdata_o (word_wdata),
        .bus_rdata_o  (bus_rdata),
        .bus_oe_o     (lane_oe)
    );

    isa_regfile #(.WORD_AW(MEM_WAW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .be_i    (word_be),
        .addr_i  (full_addr[MEM_AW-1:1]),
        .wdata_i (word_wdata),
        .rdata_o (mem_rdata)
    );

    isa_regfile #(.WORD_AW(IO_WAW)) u_io (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (io_we),
        .be_i    (word_be),
        .addr_i  (sa_s[IO_AW-1:1]),
        .wdata_i (word_wdata),
        .rdata_o (io_rdata)
    );

    // Register the bus-facing outputs: hit flags, lane enables and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m16_n_o   <= 1'b1;
            io16_n_o  <= 1'b1;
            data_oe_o <= 2'b00;
            data_o    <= '0;
        end else begin
            m16_n_o  <= !mem_hit;
            io16_n_o <= !io_hit;
            if (mem_rd || io_rd) begin
                data_oe_o <= lane_oe;
                data_o    <= bus_rdata;
            end else begin
                data_oe_o <= 2'b00;
                data_o    <= '0;
            end
        end
    end

    // R9: output enables released one clock after no decoded read remains.
    p_oe_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd && !io_rd) |=> (data_oe_o == 2'b00));

    // R5: during DMA the I/O capability flag stays deasserted.
    p_io_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        aen_s |=> io16_n_o);

    // R4: a memory window hit shows up on the flag one clock later.
    p_mem_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |=> !m16_n_o);

endmodule

// File: tb/isa_slave_front_test.sv
module isa_slave_front_test;

    localparam logic [23:0] MBASE = 24'h0D8000;
    localparam logic [15:0] IBASE = 16'h0300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_bale = 1'b0, b_aen = 1'b0, b_sbhe = 1'b1;
    logic        b_mr = 1'b1, b_mw = 1'b1, b_ir = 1'b1, b_iw = 1'b1;
    logic [6:0]  b_la = '0;
    logic [19:0] b_sa = '0;
    logic [15:0] b_d = '0;
    logic [15:0] data_o;
    logic [1:0]  data_oe_o;
    logic        m16_n_o, io16_n_o;

    int    errors = 0;
    int    checks = 0;
    string cur = "R1";

    always #4 clk = ~clk;

    isa_slave_front uut (
        .clk(clk), .rst_n(rst_n), .bale_i(b_bale), .aen_i(b_aen), .la_i(b_la),
        .sa_i(b_sa), .sbhe_n_i(b_sbhe), .mrdc_n_i(b_mr), .mwtc_n_i(b_mw),
        .iorc_n_i(b_ir), .iowc_n_i(b_iw), .data_i(b_d), .data_o(data_o),
        .data_oe_o(data_oe_o), .m16_n_o(m16_n_o), .io16_n_o(io16_n_o)
    );

    typedef struct packed {
        logic bale, aen, sbhe, mr, mw, ir, iw;
        logic [6:0]  la;
        logic [19:0] sa;
        logic [15:0] d;
    } snap_t;

    localparam snap_t IDLE = '{bale:1'b0, aen:1'b0, sbhe:1'b1, mr:1'b1,
        mw:1'b1, ir:1'b1, iw:1'b1, la:7'd0, sa:20'd0, d:16'd0};

    // Behavioural reference: input history, held address and two stores.
    snap_t       h0, h1, h2;
    logic [6:0]  mla;
    logic [15:0] mmem [16];
    logic [15:0] imem [8];
    logic        e_m16, e_io16;
    logic [1:0]  e_oe;
    logic [15:0] e_d;

    function automatic logic [15:0] put(logic [15:0] w, logic [1:0] code,
                                        logic [15:0] d);
        case (code)
            2'b00: return d;
            2'b10: return {w[15:8], d[7:0]};
            2'b01: return {d[15:8], w[7:0]};
            default: return {d[7:0], w[7:0]};
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            h0 = IDLE; h1 = IDLE; h2 = IDLE; mla = '0;
            for (int i = 0; i < 16; i++) mmem[i] = '0;
            for (int i = 0; i < 8; i++) imem[i] = '0;
            e_m16 = 1'b1; e_io16 = 1'b1; e_oe = 2'b00; e_d = '0;
        end else begin
            snap_t a, b;
            logic [6:0]  lae;
            logic [23:0] full;
            logic        mh, ih, rd;
            logic [1:0]  code;
            logic [15:0] w;
            a = h1; b = h2;
            lae  = a.bale ? a.la : mla;
            full = {lae, a.sa[16:0]};
            mh   = full[23:5] == MBASE[23:5];
            ih   = !a.aen && (a.sa[15:4] == IBASE[15:4]);
            code = {a.sbhe, a.sa[0]};
            e_m16 = !mh; e_io16 = !ih;
            rd = 1'b1; w = '0;
            if (!a.mr && mh)      w = mmem[full[4:1]];
            else if (!a.ir && ih) w = imem[a.sa[3:1]];
            else rd = 1'b0;
            if (!rd) begin e_oe = 2'b00; e_d = '0; end
            else case (code)
                2'b00: begin e_oe = 2'b11; e_d = w; end
                2'b10: begin e_oe = 2'b01; e_d = {8'h00, w[7:0]}; end
                2'b01: begin e_oe = 2'b10; e_d = {w[15:8], 8'h00}; end
                default: begin e_oe = 2'b01; e_d = {8'h00, w[15:8]}; end
            endcase
            if (a.mw && !b.mw && mh)
                mmem[full[4:1]] = put(mmem[full[4:1]], code, a.d);
            if (a.iw && !b.iw && ih)
                imem[a.sa[3:1]] = put(imem[a.sa[3:1]], code, a.d);
            if (a.bale) mla = a.la;
            h2 = h1; h1 = h0;
            h0 = '{bale:b_bale, aen:b_aen, sbhe:b_sbhe, mr:b_mr, mw:b_mw,
                   ir:b_ir, iw:b_iw, la:b_la, sa:b_sa, d:b_d};
        end
    end

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur, what, act, exp);
        end
    endtask

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("m16_n", {15'd0, m16_n_o}, {15'd0, e_m16});
            chk("io16_n", {15'd0, io16_n_o}, {15'd0, e_io16});
            chk("oe", {14'd0, data_oe_o}, {14'd0, e_oe});
            chk("data", data_o, e_d);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // One bus cycle. kind: 0 mem read, 1 mem write, 2 io read, 3 io write.
    task automatic access(int kind, logic [23:0] addr, logic sbhe,
                          logic [15:0] wd, bit scramble, bit dma);
        @(negedge clk);
        b_la = addr[23:17]; b_sa = addr[19:0]; b_sbhe = sbhe;
        b_bale = 1'b1; b_aen = dma;
        tick(2);
        if (!dma) b_bale = 1'b0;
        tick(1);
        if (scramble) b_la = ~addr[23:17];
        b_d = wd;
        case (kind)
            0: b_mr = 1'b0;
            1: b_mw = 1'b0;
            2: b_ir = 1'b0;
            default: b_iw = 1'b0;
        endcase
        tick(4);
        b_mr = 1'b1; b_mw = 1'b1; b_ir = 1'b1; b_iw = 1'b1;
        tick(4);
        b_bale = 1'b0; b_aen = 1'b0;
        tick(1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur = "R1";
        chk("reset oe", {14'd0, data_oe_o}, 16'd0);
        chk("reset data", data_o, 16'd0);
        chk("reset flags", {14'd0, m16_n_o, io16_n_o}, 16'd3);
        rst_n = 1'b1;
        tick(2);
        cur = "R1"; chk("post-reset flags", {14'd0, m16_n_o, io16_n_o}, 16'd3);

        cur = "R6";
        access(1, MBASE + 24'h00, 1'b0, 16'h1234, 0, 0);
        access(1, MBASE + 24'h02, 1'b1, 16'h55AB, 0, 0);
        access(1, MBASE + 24'h03, 1'b0, 16'hCD66, 0, 0);
        access(1, MBASE + 24'h05, 1'b1, 16'h77EF, 0, 0);
        cur = "R7";
        access(0, MBASE + 24'h00, 1'b0, 16'h0, 0, 0);
        access(0, MBASE + 24'h02, 1'b1, 16'h0, 0, 0);
        access(0, MBASE + 24'h03, 1'b0, 16'h0, 0, 0);
        access(0, MBASE + 24'h05, 1'b1, 16'h0, 0, 0);
        access(0, MBASE + 24'h04, 1'b0, 16'h0, 0, 0);
        cur = "R4";
        access(0, MBASE + 24'h1E, 1'b0, 16'h0, 0, 0);
        access(0, MBASE + 24'h20, 1'b0, 16'h0, 0, 0);
        cur = "R2";
        access(1, MBASE + 24'h08, 1'b0, 16'hA5C3, 1, 0);
        access(0, MBASE + 24'h08, 1'b0, 16'h0, 1, 0);
        cur = "R10";
        access(1, MBASE + 24'h20, 1'b0, 16'hDEAD, 0, 0);
        access(1, MBASE - 24'h02, 1'b0, 16'hBEEF, 0, 0);
        access(3, 24'h000310, 1'b0, 16'hF00D, 0, 0);
        access(0, MBASE + 24'h00, 1'b0, 16'h0, 0, 0);
        cur = "R5";
        access(3, 24'h000304, 1'b0, 16'h4321, 0, 0);
        access(2, 24'h000304, 1'b0, 16'h0, 0, 0);
        access(3, 24'h000307, 1'b1, 16'h0099, 0, 0);
        access(2, 24'h000306, 1'b0, 16'h0, 0, 0);
        cur = "R3";
        access(1, MBASE + 24'h0A, 1'b0, 16'h6789, 1, 1);
        access(0, MBASE + 24'h0A, 1'b0, 16'h0, 0, 1);
        access(0, MBASE + 24'h0A, 1'b0, 16'h0, 0, 0);
        cur = "R5";
        access(3, 24'h000302, 1'b0, 16'hBAD0, 0, 1);
        access(2, 24'h000302, 1'b0, 16'h0, 0, 1);
        access(2, 24'h000302, 1'b0, 16'h0, 0, 0);
        cur = "R8";
        access(1, MBASE + 24'h0C, 1'b0, 16'h1111, 0, 0);
        access(0, MBASE + 24'h0C, 1'b0, 16'h0, 0, 0);
        cur = "R9";
        access(0, MBASE + 24'h0C, 1'b1, 16'h0, 0, 0);
        access(2, 24'h000304, 1'b1, 16'h0, 0, 0);
        tick(5);
        cur = "R9"; chk("idle oe", {14'd0, data_oe_o}, 16'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual running expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule